// File: doc/BRIEF.md
# Fractional-Rate Time-of-Day Clock

This block keeps time of day for precision time protocol use. It has two stages, and both run on one reference clock. The first stage is a free-running counter. It holds seconds, nanoseconds and a 20-bit binary fraction of a nanosecond. Every cycle it adds a 26-bit rate word. That word has 6 integer nanosecond bits above 20 fraction bits, so software can trim the tick size very finely to follow drift. The counter starts from zero at reset and software never loads it.

The second stage adds a software-written seconds offset and nanoseconds offset to the free-running value on every cycle. The result is registered and driven out as the synchronized time. Software sets the initial time and applies step corrections only through these offsets. This leaves the rate-controlled counter undisturbed.

All three settings are written through one write port that has a select field. The nanosecond field rolls over at a parameter `NS_PER_SEC`, which defaults to one billion. Each rollover carries into a 48-bit seconds field.

Top module: `rtc_frac_top`

## Requirements
- R1: While rst_ni is low, sec_o and ns_o are zero, and the rate word and both offsets are cleared.
- R2: While the rate word is zero, the free-running time does not advance, so the outputs hold the offset value.
- R3: Each cycle the free-running counter adds the rate word to the value {nanoseconds, 20-bit fraction}. Rate bits [19:0] add to the fraction and bits [25:20] add whole nanoseconds. After k cycles at rate r, the nanosecond total is floor(k*r / 2^20), and the fraction carries, so 8.5 ns (0x880000) does not drift.
- R4: Nanoseconds stay below NS_PER_SEC. On reaching it they drop by NS_PER_SEC and carry one into seconds, both in the counter and in the offset sum.
- R5: The synchronized output equals the free-running time plus the seconds and nanoseconds offsets, including the nanosecond carry. It lags the free-running counter by one register.
- R6: A write with wr_en_i high loads the register chosen by wr_sel_i (0 = rate word from wr_data_i[25:0], 1 = seconds offset, 2 = nanoseconds offset, 3 = nothing) at that clock edge. The counter uses a new rate word from the next edge, so the output shows its first step two edges after the write.
- R7: A nanoseconds-offset write whose data is NS_PER_SEC or more is ignored, and the previous offset stays.
- R8: The seconds output wraps modulo 2^48.
- R9: Changing an offset while running steps the output by the change only. The free-running counter continues unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 rate, 1 seconds offset, 2 nanoseconds offset |
| wr_data_i | input | 48 | Write data |
| sec_o | output | 48 | Synchronized seconds |
| ns_o | output | 32 | Synchronized nanoseconds |

## Verification
The assertions check several properties on every cycle:
- nanoseconds never reach the rollover value, in the counter or at the output;
- the stored nanosecond offset is always in range;
- seconds step by at most one per cycle;
- a zero rate word freezes the counter;
- a rate write lands in the rate register one edge later.

Only the bench scenarios can show the exact accumulated value after many cycles. That includes fractional rates without drift, rollover carries, offset sums with carry, 48-bit seconds wrap, and mid-run step corrections. To exercise rollover in few cycles, a second instance runs with a rollover of 1000.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned FRAC_W = 20;
  localparam int unsigned INC_W  = 26;
  localparam int unsigned NS_OUT_W = 32;

  typedef enum logic [1:0] {
    SEL_INC    = 2'd0,
    SEL_SEC_OFF = 2'd1,
    SEL_NS_OFF = 2'd2,
    SEL_NONE   = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int unsigned NS_PER_SEC = 1_000_000_000,
  parameter int unsigned NS_W = 30,
  parameter int unsigned SEC_W = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [SEC_W-1:0]  wr_data_i,
  output logic [INC_W-1:0]  inc_o,
  output logic [SEC_W-1:0]  off_sec_o,
  output logic [NS_W-1:0]   off_ns_o
);
  localparam logic [SEC_W-1:0] NS_LIMIT = SEC_W'(NS_PER_SEC);

  logic ns_ok;
  assign ns_ok = wr_data_i < NS_LIMIT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inc_o     <= '0;
      off_sec_o <= '0;
      off_ns_o  <= '0;
    end else if (wr_en_i) begin
      unique case (wr_sel_e'(wr_sel_i))
        SEL_INC:     inc_o     <= wr_data_i[INC_W-1:0];
        SEL_SEC_OFF: off_sec_o <= wr_data_i;
        SEL_NS_OFF:  if (ns_ok) off_ns_o <= wr_data_i[NS_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rtc_accum.sv
module rtc_accum
  import rtc_pkg::*;
#(
  parameter int unsigned NS_PER_SEC = 1_000_000_000,
  parameter int unsigned NS_W = 30,
  parameter int unsigned SEC_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INC_W-1:0] inc_i,
  output logic [NS_W-1:0]  ns_o,
  output logic [SEC_W-1:0] sec_o
);
  localparam int unsigned SUM_W = NS_W + FRAC_W + 1;
  localparam logic [NS_W:0] WRAP = (NS_W+1)'(NS_PER_SEC);

  logic [FRAC_W-1:0] frac_q;
  logic [SUM_W-1:0]  sum;
  logic [NS_W:0]     ns_raw;
  logic              roll;

  // fraction and nanoseconds add as one word so the fraction carry is exact
  assign sum    = {1'b0, ns_o, frac_q} + SUM_W'(inc_i);
  assign ns_raw = sum[SUM_W-1:FRAC_W];
  assign roll   = ns_raw >= WRAP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frac_q <= '0;
      ns_o   <= '0;
      sec_o  <= '0;
    end else begin
      frac_q <= sum[FRAC_W-1:0];
      ns_o   <= roll ? NS_W'(ns_raw - WRAP) : ns_raw[NS_W-1:0];
      sec_o  <= sec_o + SEC_W'(roll);
    end
  end
endmodule

// File: rtl/rtc_offset_add.sv
module rtc_offset_add #(
  parameter int unsigned NS_PER_SEC = 1_000_000_000,
  parameter int unsigned NS_W = 30,
  parameter int unsigned SEC_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NS_W-1:0]  acc_ns_i,
  input  logic [SEC_W-1:0] acc_sec_i,
  input  logic [NS_W-1:0]  off_ns_i,
  input  logic [SEC_W-1:0] off_sec_i,
  output logic [NS_W-1:0]  ns_o,
  output logic [SEC_W-1:0] sec_o
);
  localparam logic [NS_W:0] WRAP = (NS_W+1)'(NS_PER_SEC);

  logic [NS_W:0] ns_sum;
  logic          carry;

  assign ns_sum = {1'b0, acc_ns_i} + {1'b0, off_ns_i};
  assign carry  = ns_sum >= WRAP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ns_o  <= '0;
      sec_o <= '0;
    end else begin
      ns_o  <= carry ? NS_W'(ns_sum - WRAP) : ns_sum[NS_W-1:0];
      sec_o <= acc_sec_i + off_sec_i + SEC_W'(carry);
    end
  end
endmodule

// File: rtl/rtc_frac_top.sv
module rtc_frac_top
  import rtc_pkg::*;
#(
  parameter int unsigned NS_PER_SEC = 1_000_000_000,
  parameter int unsigned SEC_W = 48
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [1:0]          wr_sel_i,
  input  logic [SEC_W-1:0]    wr_data_i,
  output logic [SEC_W-1:0]    sec_o,
  output logic [NS_OUT_W-1:0] ns_o
);
  localparam int unsigned NS_W = $clog2(NS_PER_SEC);

  logic [INC_W-1:0] inc_q;
  logic [SEC_W-1:0] off_sec_q;
  logic [NS_W-1:0]  off_ns_q;
  logic [NS_W-1:0]  acc_ns;
  logic [SEC_W-1:0] acc_sec;
  logic [NS_W-1:0]  sync_ns;

  rtc_regs #(.NS_PER_SEC(NS_PER_SEC), .NS_W(NS_W), .SEC_W(SEC_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .inc_o(inc_q), .off_sec_o(off_sec_q), .off_ns_o(off_ns_q)
  );

  rtc_accum #(.NS_PER_SEC(NS_PER_SEC), .NS_W(NS_W), .SEC_W(SEC_W)) u_accum (
    .clk_i, .rst_ni, .inc_i(inc_q), .ns_o(acc_ns), .sec_o(acc_sec)
  );

  rtc_offset_add #(.NS_PER_SEC(NS_PER_SEC), .NS_W(NS_W), .SEC_W(SEC_W)) u_offset (
    .clk_i, .rst_ni,
    .acc_ns_i(acc_ns), .acc_sec_i(acc_sec),
    .off_ns_i(off_ns_q), .off_sec_i(off_sec_q),
    .ns_o(sync_ns), .sec_o(sec_o)
  );

  assign ns_o = NS_OUT_W'(sync_ns);
endmodule

// File: rtl/rtc_frac_chk.sv
module rtc_frac_chk #(
  parameter int unsigned NS_PER_SEC = 1_000_000_000,
  parameter int unsigned NS_W = 30,
  parameter int unsigned SEC_W = 48
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       wr_sel_i,
  input logic [SEC_W-1:0] wr_data_i,
  input logic [25:0]      inc_q,
  input logic [NS_W-1:0]  off_ns_q,
  input logic [NS_W-1:0]  acc_ns,
  input logic [SEC_W-1:0] acc_sec,
  input logic [31:0]      ns_o
);
  p_acc_ns_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(acc_ns) < NS_PER_SEC);

  p_out_ns_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ns_o < NS_PER_SEC);

  p_sec_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (acc_sec == $past(acc_sec)) || (acc_sec == $past(acc_sec) + 1'b1));

  p_zero_rate_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_q == '0) |=> $stable(acc_ns) && $stable(acc_sec));

  p_rate_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd0) |=> inc_q == $past(wr_data_i[25:0]));

  p_ns_off_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(off_ns_q) < NS_PER_SEC);
endmodule

bind rtc_frac_top rtc_frac_chk #(.NS_PER_SEC(NS_PER_SEC), .NS_W(NS_W), .SEC_W(SEC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .wr_data_i(wr_data_i), .inc_q(inc_q), .off_ns_q(off_ns_q),
  .acc_ns(acc_ns), .acc_sec(acc_sec), .ns_o(ns_o)
);

// File: tb/rtc_frac_top_tb.sv
`timescale 1ns/1ps
module rtc_frac_top_tb;
  localparam longint unsigned BIG_MOD   = 1_000_000_000;
  localparam longint unsigned SMALL_MOD = 1000;
  localparam longint unsigned SEC_MASK  = 64'hFFFF_FFFF_FFFF;
  localparam int NV = 6;
  localparam logic [25:0] VEC_INC [NV] = '{26'h080_0000, 26'h088_0000, 26'h3FF_FFFF,
                                           26'h000_0001, 26'h00C_0000, 26'h200_0000};
  localparam int unsigned VEC_N [NV] = '{100, 1001, 50, 1000, 777, 40};

  logic        clk = 0;
  logic        rst_ni = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_sel = 0;
  logic [47:0] wr_data = 0;
  logic [47:0] sec_b, sec_s;
  logic [31:0] ns_b, ns_s;

  int checks = 0, failures = 0;
  longint unsigned edges = 0, inc_m = 0, soff_m = 0, noff_b = 0, noff_s = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtc_frac_top u_dut (.clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_sel_i(wr_sel),
                      .wr_data_i(wr_data), .sec_o(sec_b), .ns_o(ns_b));
  rtc_frac_top #(.NS_PER_SEC(1000)) u_small (.clk_i(clk), .rst_ni, .wr_en_i(wr_en),
                      .wr_sel_i(wr_sel), .wr_data_i(wr_data), .sec_o(sec_s), .ns_o(ns_s));

  function automatic void model(input longint unsigned k, input longint unsigned md,
                                input longint unsigned noff,
                                output longint unsigned e_sec, output longint unsigned e_ns);
    longint unsigned tot, a_sec, a_ns, s, c;
    tot   = (k * inc_m) >> 20;
    a_sec = tot / md;
    a_ns  = tot % md;
    s     = a_ns + noff;
    c     = (s >= md) ? 1 : 0;
    e_ns  = (c != 0) ? s - md : s;
    e_sec = (a_sec + soff_m + c) & SEC_MASK;
  endfunction

  task automatic cmp(input string tag, input string which,
                     input longint unsigned a_sec, input longint unsigned a_ns,
                     input longint unsigned e_sec, input longint unsigned e_ns);
    checks++;
    if (a_sec != e_sec || a_ns != e_ns) begin
      failures++;
      $display("FAIL %s [%s] actual sec=%0d ns=%0d expected sec=%0d ns=%0d",
               tag, which, a_sec, a_ns, e_sec, e_ns);
    end
  endtask

  // compare both instances against the model; output reflects accumulator after edges-1 steps
  task automatic check_both(input string tag);
    longint unsigned es, en, k;
    k = (edges == 0) ? 0 : edges - 1;
    model(k, BIG_MOD, noff_b, es, en);
    cmp(tag, "big", longint'(sec_b), longint'(ns_b), es, en);
    model(k, SMALL_MOD, noff_s, es, en);
    cmp(tag, "small", longint'(sec_s), longint'(ns_s), es, en);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      edges++;
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [47:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    tick(1);
    wr_en = 0; wr_sel = 2'd3; wr_data = '0;
    case (sel)
      2'd0: begin inc_m = longint'(d[25:0]); edges = 0; end
      2'd1: soff_m = longint'(d);
      2'd2: begin
        if (longint'(d) < BIG_MOD) noff_b = longint'(d);
        if (longint'(d) < SMALL_MOD) noff_s = longint'(d);
      end
      default: ;
    endcase
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; wr_en = 0;
    inc_m = 0; soff_m = 0; noff_b = 0; noff_s = 0; edges = 0;
    repeat (2) @(negedge clk);
    check_both("R1 reset");
    rst_ni = 1;
  endtask

  initial begin
    // R1 / R2: reset clears, zero rate holds
    do_reset();
    tick(20);
    check_both("R2 zero rate holds");

    // R7: out-of-range ns offset ignored (small instance), in range accepted (big)
    wr(2'd2, 48'd999_999_999);
    tick(2);
    check_both("R7 ns offset range");

    // R6: write with wr_en low has no effect
    wr_en = 0; wr_sel = 2'd1; wr_data = 48'd77;
    tick(2);
    check_both("R6 write strobe low ignored");

    // R3/R4: table of rates and cycle counts
    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(2'd0, 48'(VEC_INC[i]));
      tick(int'(VEC_N[i]) + 1);
      check_both($sformatf("R3 R4 vector %0d", i));
    end

    // R6: latency of a rate write
    do_reset();
    wr(2'd0, 48'h080_0000);
    tick(1);
    check_both("R6 one edge after rate write");
    tick(1);
    check_both("R6 first step visible");

    // R5: offsets with ns carry
    do_reset();
    wr(2'd1, 48'd5);
    wr(2'd2, 48'd999_999_995);
    wr(2'd0, 48'h080_0000);
    tick(3);
    check_both("R5 offset sum with carry");

    // R9: step correction while running
    wr(2'd2, 48'd100);
    tick(4);
    check_both("R9 step correction");
    tick(200);
    check_both("R9 counter keeps running");

    // R8: seconds wrap
    do_reset();
    wr(2'd1, 48'hFFFF_FFFF_FFFF);
    wr(2'd2, 48'd999_999_990);
    wr(2'd0, 48'h080_0000);
    tick(3);
    check_both("R8 seconds wrap");

    // R3: 8.5 ns long run, no drift
    do_reset();
    wr(2'd0, 48'h088_0000);
    tick(5001);
    check_both("R3 fractional long run");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule